// File: doc/BRIEF.md
# Special-Register Access Checker

This block sits between the instruction pipeline and the special-register storage of a processor core. Every move-to or move-from special-register request passes through it. The block checks the privilege bits of the status register. It then sorts the 16-bit register address into readable, writable, jump-target, timer-mode or unknown. From that it produces the enables for the register bank, and it raises an error pulse when it refuses a request.

An address is built as the group number shifted left by 11, ORed with the index inside the group. The system registers occupy group 0, and this includes a window of 512 shadow general registers that starts at index 1024. The multiply-accumulate result halves are in group 5, and the timer mode register is in group 10. The register bank sits behind the checker. The bank answers a read in the same cycle as the enable, through `rf_rdata_i`.

A write to the next-PC address does not reach the bank. Instead it becomes a jump request that carries the written value. The pipeline also takes this request as the signal to drop any pending delay-slot state. Every output is registered, so each one appears in the cycle after the request strobe.

Top module: `spr_access_checker`

## Requirements
- R1: A request is allowed when `sr_super_i` or `sr_user_spr_i` is 1. When neither bit is set, a read or write strobe produces no bank enable and no jump. Instead it produces `err_priv_o`=1 for one cycle, and `err_inval_o` stays 0.
- R2: An allowed read of the version (0x0000), unit-present (0x0001), CPU-config (0x0002), status (0x0011), previous-PC (0x0012), FP-control (0x0014), exception-PC (0x0020), MAC-low (0x2801) or MAC-high (0x2802) address, or of the general-register window, drives `rf_rd_en_o`=1 and `rf_addr_o`=address one cycle later. `rd_data_o` then equals `rf_rdata_i`.
- R3: An allowed write to the FP-control, exception-PC, exception-status (0x0040), status, MAC-low or MAC-high address, or to the window, drives `rf_wr_en_o`=1 one cycle later, with `rf_addr_o` and `rf_wdata_o` equal to the request.
- R4: An allowed write to next-PC (0x0010) drives `pc_redirect_o`=1 and `pc_target_o`=write data one cycle later. It does not drive `rf_wr_en_o`. Reading next-PC is invalid.
- R5: A write to the timer mode address (0x5000) is forwarded to the bank only when the data is zero. Nonzero data gives `err_inval_o`=1 and no bank write.
- R6: Any other allowed access gives `err_inval_o`=1 and no enable. While `rf_rd_en_o` is 0, `rd_data_o` is zero. This covers reads of exception-status and next-PC.
- R7: The general-register window covers addresses 0x0400 to 0x05FF inclusive. Addresses 0x03FF and 0x0600 are invalid.
- R8: After reset, all outputs are zero. Each output pulse lasts exactly one cycle for a one-cycle strobe.
- R9: A read and a write strobed in the same cycle are judged independently on the same address. `err_inval_o` is set if either one is illegal, and each legal part still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spr_addr_i | input | 16 | Requested register address |
| spr_wdata_i | input | 32 | Write data of the request |
| spr_rd_i | input | 1 | Read strobe |
| spr_wr_i | input | 1 | Write strobe |
| sr_super_i | input | 1 | Status register supervisor bit |
| sr_user_spr_i | input | 1 | Status register bit granting user access |
| rf_rdata_i | input | 32 | Read data returned by the bank |
| rf_rd_en_o | output | 1 | Bank read enable |
| rf_wr_en_o | output | 1 | Bank write enable |
| rf_addr_o | output | 16 | Bank address |
| rf_wdata_o | output | 32 | Bank write data |
| rd_data_o | output | 32 | Read result, zero when no read was granted |
| pc_redirect_o | output | 1 | Jump request, also clears delay-slot state |
| pc_target_o | output | 32 | Jump target |
| err_priv_o | output | 1 | Request refused for privilege |
| err_inval_o | output | 1 | Request refused for address or data |

## Verification
The read path and the write path can both be active in the same cycle, on one address. This can give a mixed result, for example a jump together with an invalid-read error when next-PC is accessed both ways. The bench strobes read and write together across every group-0 address and the first indices of every other group. It does this under all four privilege-bit combinations, so both legal and illegal halves meet. Each case is judged by comparing every output against a model that treats the read set and the write set as separate lists, with errors ORed.

// File: rtl/spr_chk_pkg.sv
// Package: address constants and the classification record shared by the
// special-register checker. Assumes addresses are (group << 11) | index.
package spr_chk_pkg;

    localparam int unsigned SPR_AW    = 16;
    localparam int unsigned GRP_SHIFT = 11;

    // Build an address from group and index.
    function automatic logic [SPR_AW-1:0] spr_at(input int unsigned grp,
                                                 input int unsigned idx);
        return SPR_AW'((grp << GRP_SHIFT) | idx);
    endfunction

    localparam logic [SPR_AW-1:0] A_VERSION = spr_at(0, 0);
    localparam logic [SPR_AW-1:0] A_UNITS   = spr_at(0, 1);
    localparam logic [SPR_AW-1:0] A_CPUCFG  = spr_at(0, 2);
    localparam logic [SPR_AW-1:0] A_NEXTPC  = spr_at(0, 16);
    localparam logic [SPR_AW-1:0] A_STATUS  = spr_at(0, 17);
    localparam logic [SPR_AW-1:0] A_PREVPC  = spr_at(0, 18);
    localparam logic [SPR_AW-1:0] A_FPCTL   = spr_at(0, 20);
    localparam logic [SPR_AW-1:0] A_EXC_PC  = spr_at(0, 32);
    localparam logic [SPR_AW-1:0] A_EXC_SR  = spr_at(0, 64);
    localparam logic [SPR_AW-1:0] A_MAC_LO  = spr_at(5, 1);
    localparam logic [SPR_AW-1:0] A_MAC_HI  = spr_at(5, 2);
    localparam logic [SPR_AW-1:0] A_TMODE   = spr_at(10, 0);

    typedef struct packed {
        logic rd_legal;   // address may be read
        logic wr_plain;   // address may be written unconditionally
        logic npc;        // address is the jump target register
        logic tmode;      // address is the timer mode register
    } spr_class_t;

endpackage

// File: rtl/spr_addr_class.sv
// Address classifier: sorts a register address into the readable list, the
// plain-writable list, the jump register and the timer mode register.
// Purely combinational; assumes the general-register window lies in group 0.
module spr_addr_class
    import spr_chk_pkg::*;
#(
    parameter int unsigned GPR_BASE  = 1024,
    parameter int unsigned GPR_COUNT = 512
) (
    input  logic [SPR_AW-1:0] addr_i,
    output spr_class_t        cls_o
);

    localparam int unsigned N_RD = 9;
    localparam int unsigned N_WR = 6;
    localparam logic [SPR_AW-1:0] GPR_LO = SPR_AW'(GPR_BASE);
    localparam logic [SPR_AW-1:0] GPR_HI = SPR_AW'(GPR_BASE + GPR_COUNT - 1);

    localparam logic [SPR_AW-1:0] RD_LIST [N_RD] = '{
        A_MAC_HI, A_EXC_PC, A_STATUS, A_VERSION, A_FPCTL,
        A_UNITS, A_MAC_LO, A_PREVPC, A_CPUCFG
    };
    localparam logic [SPR_AW-1:0] WR_LIST [N_WR] = '{
        A_EXC_SR, A_MAC_LO, A_STATUS, A_FPCTL, A_MAC_HI, A_EXC_PC
    };

    logic [N_RD-1:0] rd_hit;
    logic [N_WR-1:0] wr_hit;
    logic            in_gpr;

    // One comparator per readable address.
    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_hit[g] = (addr_i == RD_LIST[g]);
    end

    // One comparator per plain-writable address.
    for (genvar g = 0; g < N_WR; g++) begin : g_wr
        assign wr_hit[g] = (addr_i == WR_LIST[g]);
    end

    // Inclusive window check for the shadow general registers.
    always_comb begin
        in_gpr = (addr_i >= GPR_LO) && (addr_i <= GPR_HI);
    end

    // Assemble the classification record.
    always_comb begin
        cls_o.rd_legal = (|rd_hit) || in_gpr;
        cls_o.wr_plain = (|wr_hit) || in_gpr;
        cls_o.npc      = (addr_i == A_NEXTPC);
        cls_o.tmode    = (addr_i == A_TMODE);
    end

    // The write categories are mutually exclusive.
    always_comb begin
        AST_WR_CLASS_EXCL: assert ($onehot0({cls_o.wr_plain, cls_o.npc, cls_o.tmode})); // R4
    end

endmodule

// File: rtl/spr_priv_gate.sv
// Privilege and legality gate: combines the strobes, the status register
// privilege bits and the address class into grant and refusal decisions.
// Purely combinational; assumes the class matches the current address.
module spr_priv_gate
    import spr_chk_pkg::*;
(
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic       super_i,
    input  logic       user_spr_i,
    input  logic       wdata_zero_i,
    input  spr_class_t cls_i,
    output logic       rd_ok_o,
    output logic       wr_ok_o,
    output logic       jump_ok_o,
    output logic       deny_o,
    output logic       bad_o
);

    logic allowed;
    logic wr_legal;

    // Privilege decision and write legality for the current address and data.
    always_comb begin
        allowed  = super_i || user_spr_i;
        wr_legal = cls_i.wr_plain || (cls_i.tmode && wdata_zero_i);
    end

    // Grants and refusals; read and write are judged independently.
    always_comb begin
        rd_ok_o   = allowed && rd_i && cls_i.rd_legal;
        wr_ok_o   = allowed && wr_i && wr_legal;
        jump_ok_o = allowed && wr_i && cls_i.npc;
        deny_o    = !allowed && (rd_i || wr_i);
        bad_o     = allowed && ((rd_i && !cls_i.rd_legal) ||
                                (wr_i && !wr_legal && !cls_i.npc));
    end

endmodule

// File: rtl/spr_access_checker.sv
// Special-register access checker, top level. It classifies each request,
// gates it on privilege and registers all results, so every output appears
// in the cycle after the strobe. Assumes the bank answers a read in the
// same cycle as rf_rd_en_o.
module spr_access_checker
    import spr_chk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned GPR_BASE  = 1024,
    parameter int unsigned GPR_COUNT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPR_AW-1:0] spr_addr_i,
    input  logic [DATA_W-1:0] spr_wdata_i,
    input  logic              spr_rd_i,
    input  logic              spr_wr_i,
    input  logic              sr_super_i,
    input  logic              sr_user_spr_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_rd_en_o,
    output logic              rf_wr_en_o,
    output logic [SPR_AW-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pc_redirect_o,
    output logic [DATA_W-1:0] pc_target_o,
    output logic              err_priv_o,
    output logic              err_inval_o
);

    spr_class_t cls;
    logic       rd_ok, wr_ok, jump_ok, deny, bad;

    spr_addr_class #(
        .GPR_BASE  (GPR_BASE),
        .GPR_COUNT (GPR_COUNT)
    ) class_i (
        .addr_i (spr_addr_i),
        .cls_o  (cls)
    );

    spr_priv_gate gate_i (
        .rd_i         (spr_rd_i),
        .wr_i         (spr_wr_i),
        .super_i      (sr_super_i),
        .user_spr_i   (sr_user_spr_i),
        .wdata_zero_i (spr_wdata_i == '0),
        .cls_i        (cls),
        .rd_ok_o      (rd_ok),
        .wr_ok_o      (wr_ok),
        .jump_ok_o    (jump_ok),
        .deny_o       (deny),
        .bad_o        (bad)
    );

    // Register grants, refusals and the request fields one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_rd_en_o    <= 1'b0;
            rf_wr_en_o    <= 1'b0;
            rf_addr_o     <= '0;
            rf_wdata_o    <= '0;
            pc_redirect_o <= 1'b0;
            pc_target_o   <= '0;
            err_priv_o    <= 1'b0;
            err_inval_o   <= 1'b0;
        end else begin
            rf_rd_en_o    <= rd_ok;
            rf_wr_en_o    <= wr_ok;
            rf_addr_o     <= (spr_rd_i || spr_wr_i) ? spr_addr_i : '0;
            rf_wdata_o    <= wr_ok ? spr_wdata_i : '0;
            pc_redirect_o <= jump_ok;
            pc_target_o   <= jump_ok ? spr_wdata_i : '0;
            err_priv_o    <= deny;
            err_inval_o   <= bad;
        end
    end

    // Pass bank data only for a granted read.
    always_comb begin
        rd_data_o = rf_rd_en_o ? rf_rdata_i : '0;
    end

    AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_priv_o |-> !rf_rd_en_o && !rf_wr_en_o && !pc_redirect_o && !err_inval_o); // R1
    AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_priv_o || err_inval_o) |-> $past(spr_rd_i || spr_wr_i)); // R8
    AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect_o |-> !rf_wr_en_o && rf_addr_o == A_NEXTPC); // R4
    AST_TMODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en_o && rf_addr_o == A_TMODE) |-> rf_wdata_o == '0); // R5
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_rd_en_o |-> rd_data_o == '0); // R6
    AST_NPC_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |-> rf_addr_o != A_NEXTPC && rf_addr_o != A_EXC_SR); // R2

endmodule

// File: tb/spr_access_checker_tb_top.sv
// Bench: sweeps addresses, privilege bits and read/write combinations and
// compares every output against an arithmetic model of the requirements.
module spr_access_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0, wr = 1'b0, sm = 1'b0, us = 1'b0;
    logic [31:0] rf_rdata;
    logic        rf_rd_en, rf_wr_en, redir, e_priv, e_inval;
    logic [15:0] rf_addr;
    logic [31:0] rf_wdata, rd_data, target;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    // Bank model: data is a fixed function of the address.
    assign rf_rdata = {~rf_addr, rf_addr};

    spr_access_checker dut_i (
        .clk(clk), .rst_n(rst_n), .spr_addr_i(addr), .spr_wdata_i(wdata),
        .spr_rd_i(rd), .spr_wr_i(wr), .sr_super_i(sm), .sr_user_spr_i(us),
        .rf_rdata_i(rf_rdata), .rf_rd_en_o(rf_rd_en), .rf_wr_en_o(rf_wr_en),
        .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rd_data_o(rd_data),
        .pc_redirect_o(redir), .pc_target_o(target),
        .err_priv_o(e_priv), .err_inval_o(e_inval)
    );

    function automatic bit in_win(input int a);
        return a >= 1024 && a <= 1535;
    endfunction

    function automatic bit can_read(input int a);
        return a == 0 || a == 1 || a == 2 || a == 17 || a == 18 || a == 20 ||
               a == 32 || a == 5*2048+1 || a == 5*2048+2 || in_win(a);
    endfunction

    function automatic bit can_write(input int a);
        return a == 20 || a == 32 || a == 64 || a == 17 ||
               a == 5*2048+1 || a == 5*2048+2 || in_win(a);
    endfunction

    function automatic string tag_of(input int a, input bit r, input bit w,
                                     input bit ok);
        if (!ok) return "R1";
        if (r && w) return "R9";
        if (a == 16) return "R4";
        if (a == 10*2048) return "R5";
        if (a >= 1020 && a <= 1540 && !(a > 1027 && a < 1532)) return "R7";
        if (r && can_read(a)) return "R2";
        if (w && can_write(a)) return "R3";
        return "R6";
    endfunction

    // One access: drive, check the registered response, then check it ends.
    task automatic access(input int a, input logic [31:0] d, input bit r,
                          input bit w, input bit s, input bit u);
        bit ok, erd, ewr, ejmp, ebad, eprv;
        logic [31:0] erdat, ewd, etgt;
        logic [15:0] eaddr;
        @(negedge clk);
        addr = 16'(a); wdata = d; rd = r; wr = w; sm = s; us = u;
        @(posedge clk);
        #2 rd = 1'b0; wr = 1'b0;
        ok   = s || u;
        erd  = ok && r && can_read(a);
        ewr  = ok && w && (can_write(a) || (a == 10*2048 && d == 0));
        ejmp = ok && w && a == 16;
        eprv = !ok && (r || w);
        ebad = ok && ((r && !can_read(a)) || (w && !ewr && !ejmp));
        eaddr = 16'(a);
        erdat = erd ? {~eaddr, eaddr} : 32'h0;
        ewd   = ewr ? d : 32'h0;
        etgt  = ejmp ? d : 32'h0;
        @(negedge clk);
        checks++;
        if ({rf_rd_en, rf_wr_en, redir, e_priv, e_inval} != {erd, ewr, ejmp, eprv, ebad} ||
            rf_addr != eaddr || rf_wdata != ewd || target != etgt || rd_data != erdat) begin
            errors++;
            $display("FAIL %s addr=%h r=%0b w=%0b sm=%0b us=%0b: flags=%b/%b addr=%h/%h wd=%h/%h tgt=%h/%h rdat=%h/%h",
                     tag_of(a, r, w, ok), eaddr, r, w, s, u,
                     {rf_rd_en, rf_wr_en, redir, e_priv, e_inval},
                     {erd, ewr, ejmp, eprv, ebad}, rf_addr, eaddr,
                     rf_wdata, ewd, target, etgt, rd_data, erdat);
        end
        @(negedge clk);
        checks++;   // R8 pulses last a single cycle
        if ({rf_rd_en, rf_wr_en, redir, e_priv, e_inval} != 5'b0 || rd_data != 0) begin
            errors++;
            $display("FAIL R8 pulse not single-cycle at addr=%h: flags=%b expected 00000",
                     eaddr, {rf_rd_en, rf_wr_en, redir, e_priv, e_inval});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R8 reset state
        if ({rf_rd_en, rf_wr_en, redir, e_priv, e_inval} != 5'b0 || rf_addr != 0 ||
            rf_wdata != 0 || target != 0 || rd_data != 0) begin
            errors++;
            $display("FAIL R8 reset state: flags=%b expected 00000",
                     {rf_rd_en, rf_wr_en, redir, e_priv, e_inval});
        end
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++) begin
            for (int op = 1; op < 4; op++) begin
                for (int a = 0; a < 2048; a++)
                    access(a, ((a % 3) == 0) ? 32'h0 : 32'(a * 7 + 1),
                           op[0], op[1], p[0], p[1]);
                for (int g = 1; g < 32; g++) begin
                    for (int i = 0; i < 4; i++)
                        access(g * 2048 + i, (i[0]) ? 32'h0 : 32'(g * 97 + i + 5),
                               op[0], op[1], p[0], p[1]);
                end
            end
        end
        // R5 nonzero timer write with supervisor only, R4 jump with all-ones target
        access(10*2048, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 1'b0);
        access(16, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule